// File: doc/BRIEF.md
# Per-Bank Row-Hit-First Request Scheduler

This block holds pending memory requests in one ordered queue per bank and, when asked about a bank, decides what that bank should do next. Each request carries a bank, row, column, read/write flag and tag. A request is appended at the tail of its bank's queue, so the head is always the oldest entry.

A query names a bank and supplies that bank's open-row state. The row-state tracker provides it as a valid flag and a row number. If the bank has an open row and any queued request targets it, the oldest such request wins. It leaves the queue and the block issues a column read or write for it. Without a row hit, the head request is reported together with the command that prepares the bank: activate if the bank is closed, precharge if another row is open. The head then stays queued. The block does no timing bookkeeping. The result appears in registers one cycle after the query.

A two-state controller sequences the result port. `ST_IDLE` moves to `ST_REPORT` on a query, which is the report transition. `ST_REPORT` stays in `ST_REPORT` when a new query arrives straight away, and otherwise returns to `ST_IDLE`, which is the retire transition. `ST_IDLE` stays idle while there is no query.

Top module: `row_hit_first_sched`

## Requirements
- R1: After reset `res_valid` is 0 and `push_ready` is 1 for every bank.
- R2: A query on a bank whose queue is empty reports command NOP, encoded 0, with that bank number.
- R3: `push_ready` is 0 when the addressed bank already holds DEPTH entries. A push offered while `push_ready` is 0 is not stored.
- R4: With an open row, the oldest queued entry whose row equals the open row is reported with command RD, encoded 3, if its write flag is 0, or WR, encoded 4, if it is 1. That entry is removed from the queue.
- R5: With the bank closed, no entry is a hit. The head entry is reported with ACT, encoded 1, and stays queued.
- R6: With a row open and no entry matching it, the head entry is reported with PRE, encoded 2, and stays queued.
- R7: `res_valid` is 1 exactly in the cycle after a query strobe, and 0 in the cycle after a cycle without a query.
- R8: A push and a hit removal on the same bank in the same cycle are both honoured. After a removal from the middle of a queue, the remaining entries keep their relative order, and the new entry goes to the tail.
- R9: Banks are independent. Pushes and removals on one bank do not change another bank's queue, and the result carries the queried bank number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_valid | input | 1 | Offer a new request |
| push_bank | input | BANK_W | Target bank of the new request |
| push_row | input | ROW_W | Row of the new request |
| push_col | input | COL_W | Column of the new request |
| push_wr | input | 1 | 1 for a write, 0 for a read |
| push_tag | input | TAG_W | Requester tag |
| push_ready | output | 1 | The addressed bank queue has room |
| query_valid | input | 1 | Query strobe |
| query_bank | input | BANK_W | Bank being queried |
| open_valid | input | 1 | The queried bank has an open row |
| open_row | input | ROW_W | Open row of the queried bank |
| res_valid | output | 1 | Result valid, one cycle after the query |
| res_cmd | output | 3 | 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR |
| res_bank | output | BANK_W | Queried bank |
| res_row | output | ROW_W | Row of the reported entry |
| res_col | output | COL_W | Column of the reported entry |
| res_tag | output | TAG_W | Tag of the reported entry |

## Verification
The embedded properties check, on every cycle, the following: the one-cycle result latency, that no queue takes a push while full, and that a removal points inside the occupied part of the queue. They also check that a column command matches the open row it was asked about, that an activate follows only a closed-bank query, and that a precharge names a row different from the open one. Which entry is picked depends on the whole queue history, so only the bench scenarios can show the following. The oldest hit wins over younger hits. Missed entries really stay queued. Order survives a middle removal combined with a simultaneous push. A rejected push leaves no trace when the queue is later drained.

// File: rtl/rhf_pkg.sv
package rhf_pkg;
    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_PRE = 3'd2,
        CMD_RD  = 3'd3,
        CMD_WR  = 3'd4
    } cmd_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_REPORT = 1'b1
    } state_e;
endpackage

// File: rtl/rhf_bank_queue.sv
// Ordered per-bank request store: tail append, removal at any index with compaction.
module rhf_bank_queue #(
    parameter int DEPTH = 8,
    parameter int ENT_W = 13,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   push_en,
    input  logic [ENT_W-1:0]       push_data,
    input  logic                   rm_en,
    input  logic [IDX_W-1:0]       rm_idx,
    output logic [DEPTH*ENT_W-1:0] ent_flat,
    output logic [CNT_W-1:0]       count,
    output logic                   full
);
    logic [ENT_W-1:0] ent_q [DEPTH];
    logic [ENT_W-1:0] ent_n [DEPTH];
    logic [CNT_W-1:0] wpos;

    always_comb begin
        wpos = count - CNT_W'(rm_en);
        for (int i = 0; i < DEPTH; i++) begin
            ent_n[i] = ent_q[i];
            if (rm_en && (IDX_W'(i) >= rm_idx) && (i < DEPTH - 1)) begin
                ent_n[i] = ent_q[i+1];
            end
            if (push_en && (CNT_W'(i) == wpos)) begin
                ent_n[i] = push_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else begin
            count <= count + CNT_W'(push_en) - CNT_W'(rm_en);
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= ent_n[i];
        end
    end

    assign full = (count == CNT_W'(DEPTH));

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_flat
            assign ent_flat[g*ENT_W +: ENT_W] = ent_q[g];
        end
    endgenerate

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> (count < CNT_W'(DEPTH)));

    p_remove_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rm_en |-> (CNT_W'(rm_idx) < count));
endmodule

// File: rtl/rhf_hit_picker.sv
// Finds the lowest-index (oldest) occupied entry whose row equals the open row.
module rhf_hit_picker #(
    parameter int DEPTH   = 8,
    parameter int ENT_W   = 13,
    parameter int ROW_W   = 4,
    parameter int ROW_LSB = 9,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic [DEPTH*ENT_W-1:0] ent_flat,
    input  logic [CNT_W-1:0]       count,
    input  logic                   open_valid,
    input  logic [ROW_W-1:0]       open_row,
    output logic                   hit,
    output logic [IDX_W-1:0]       hit_idx
);
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (open_valid && (CNT_W'(i) < count) &&
                (ent_flat[i*ENT_W + ROW_LSB +: ROW_W] == open_row)) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/row_hit_first_sched.sv
module row_hit_first_sched
    import rhf_pkg::*;
#(
    parameter int NB    = 4,
    parameter int DEPTH = 8,
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int TAG_W = 4,
    localparam int BANK_W  = (NB > 1) ? $clog2(NB) : 1,
    localparam int ENT_W   = ROW_W + COL_W + 1 + TAG_W,
    localparam int ROW_LSB = COL_W + 1 + TAG_W,
    localparam int COL_LSB = 1 + TAG_W,
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_valid,
    input  logic [BANK_W-1:0] push_bank,
    input  logic [ROW_W-1:0]  push_row,
    input  logic [COL_W-1:0]  push_col,
    input  logic              push_wr,
    input  logic [TAG_W-1:0]  push_tag,
    output logic              push_ready,
    input  logic              query_valid,
    input  logic [BANK_W-1:0] query_bank,
    input  logic              open_valid,
    input  logic [ROW_W-1:0]  open_row,
    output logic              res_valid,
    output logic [2:0]        res_cmd,
    output logic [BANK_W-1:0] res_bank,
    output logic [ROW_W-1:0]  res_row,
    output logic [COL_W-1:0]  res_col,
    output logic [TAG_W-1:0]  res_tag
);
    logic [DEPTH*ENT_W-1:0] ent_all  [NB];
    logic [CNT_W-1:0]       cnt_all  [NB];
    logic                   full_all [NB];

    logic [ENT_W-1:0]       push_data;
    logic [DEPTH*ENT_W-1:0] sel_ent;
    logic [CNT_W-1:0]       sel_cnt;
    logic                   sel_hit;
    logic [IDX_W-1:0]       sel_idx;
    logic [ENT_W-1:0]       pick;
    cmd_e                   pick_cmd;
    state_e                 state_q, state_n;

    assign push_data  = {push_row, push_col, push_wr, push_tag};
    assign push_ready = !full_all[push_bank];
    assign sel_ent    = ent_all[query_bank];
    assign sel_cnt    = cnt_all[query_bank];

    generate
        for (genvar b = 0; b < NB; b++) begin : g_bank
            rhf_bank_queue #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_q (
                .clk      (clk),
                .rst_n    (rst_n),
                .push_en  (push_valid && !full_all[b] && (push_bank == BANK_W'(b))),
                .push_data(push_data),
                .rm_en    (query_valid && sel_hit && (query_bank == BANK_W'(b))),
                .rm_idx   (sel_idx),
                .ent_flat (ent_all[b]),
                .count    (cnt_all[b]),
                .full     (full_all[b])
            );
        end
    endgenerate

    rhf_hit_picker #(.DEPTH(DEPTH), .ENT_W(ENT_W), .ROW_W(ROW_W), .ROW_LSB(ROW_LSB)) u_pick (
        .ent_flat  (sel_ent),
        .count     (sel_cnt),
        .open_valid(open_valid),
        .open_row  (open_row),
        .hit       (sel_hit),
        .hit_idx   (sel_idx)
    );

    // Decision: empty -> NOP, hit -> column command, otherwise prepare the head.
    always_comb begin
        if (sel_hit) begin
            pick     = sel_ent[sel_idx*ENT_W +: ENT_W];
            pick_cmd = pick[TAG_W] ? CMD_WR : CMD_RD;
        end else begin
            pick     = sel_ent[ENT_W-1:0];
            pick_cmd = open_valid ? CMD_PRE : CMD_ACT;
        end
        if (sel_cnt == '0) pick_cmd = CMD_NOP;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_n = query_valid ? ST_REPORT : ST_IDLE;
            ST_REPORT: state_n = query_valid ? ST_REPORT : ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_cmd  <= CMD_NOP;
            res_bank <= '0;
            res_row  <= '0;
            res_col  <= '0;
            res_tag  <= '0;
        end else if (query_valid) begin
            res_cmd  <= pick_cmd;
            res_bank <= query_bank;
            res_row  <= pick[ROW_LSB +: ROW_W];
            res_col  <= pick[COL_LSB +: COL_W];
            res_tag  <= pick[TAG_W-1:0];
        end
    end

    assign res_valid = (state_q == ST_REPORT);

    p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        query_valid |=> res_valid);

    p_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !query_valid |=> !res_valid);

    p_hit_row_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_cmd == CMD_RD || res_cmd == CMD_WR)) |->
        ($past(open_valid) && res_row == $past(open_row)));

    p_act_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cmd == CMD_ACT) |-> !$past(open_valid));

    p_pre_other_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_cmd == CMD_PRE) |->
        ($past(open_valid) && res_row != $past(open_row)));

    p_bank_echo_r9: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_bank == $past(query_bank)));
endmodule

// File: tb/row_hit_first_sched_test.sv
module row_hit_first_sched_test;
    localparam int NB = 4, DEPTH = 8, ROW_W = 4, COL_W = 4, TAG_W = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic push_valid = 0, push_wr = 0, query_valid = 0, open_valid = 0;
    logic [1:0] push_bank = 0, query_bank = 0;
    logic [ROW_W-1:0] push_row = 0, open_row = 0;
    logic [COL_W-1:0] push_col = 0;
    logic [TAG_W-1:0] push_tag = 0;
    logic push_ready, res_valid;
    logic [2:0] res_cmd;
    logic [1:0] res_bank;
    logic [ROW_W-1:0] res_row;
    logic [COL_W-1:0] res_col;
    logic [TAG_W-1:0] res_tag;

    int checks = 0, errors = 0;
    bit done = 0;

    int mrow [NB][DEPTH];
    int mcol [NB][DEPTH];
    int mwr  [NB][DEPTH];
    int mtag [NB][DEPTH];
    int mcnt [NB];

    always #2 clk = ~clk;

    row_hit_first_sched #(.NB(NB), .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .TAG_W(TAG_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .push_valid(push_valid), .push_bank(push_bank), .push_row(push_row),
        .push_col(push_col), .push_wr(push_wr), .push_tag(push_tag), .push_ready(push_ready),
        .query_valid(query_valid), .query_bank(query_bank),
        .open_valid(open_valid), .open_row(open_row),
        .res_valid(res_valid), .res_cmd(res_cmd), .res_bank(res_bank),
        .res_row(res_row), .res_col(res_col), .res_tag(res_tag)
    );

    task automatic check(string rq, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
        end
    endtask

    task automatic drop_entry(int b, int k);
        for (int i = k; i < mcnt[b] - 1; i++) begin
            mrow[b][i] = mrow[b][i+1]; mcol[b][i] = mcol[b][i+1];
            mwr[b][i]  = mwr[b][i+1];  mtag[b][i] = mtag[b][i+1];
        end
        mcnt[b]--;
    endtask

    // One cycle of stimulus; open < 0 means the queried bank is closed.
    task automatic step(bit dp, int pb, int pr, int pc, int pw, int pt,
                        bit dq, int qb, int open, string rq);
        int ecmd, erow, ecol, etag, hit;
        @(negedge clk);
        push_valid = dp; push_bank = 2'(pb); push_row = ROW_W'(pr);
        push_col = COL_W'(pc); push_wr = pw[0]; push_tag = TAG_W'(pt);
        query_valid = dq; query_bank = 2'(qb);
        open_valid = (open >= 0); open_row = ROW_W'(open < 0 ? 0 : open);
        ecmd = 0; erow = 0; ecol = 0; etag = 0;
        if (dq) begin
            hit = -1;
            if (open >= 0)
                for (int i = mcnt[qb] - 1; i >= 0; i--) if (mrow[qb][i] == open) hit = i;
            if (mcnt[qb] == 0) ecmd = 0;
            else if (hit >= 0) begin
                ecmd = mwr[qb][hit] ? 4 : 3;
                erow = mrow[qb][hit]; ecol = mcol[qb][hit]; etag = mtag[qb][hit];
                drop_entry(qb, hit);
            end else begin
                ecmd = (open >= 0) ? 2 : 1;
                erow = mrow[qb][0]; ecol = mcol[qb][0]; etag = mtag[qb][0];
            end
        end
        #1;
        if (dp) begin
            check("R3 push_ready", int'(push_ready), int'(mcnt[pb] < DEPTH));
            if (mcnt[pb] < DEPTH) begin
                mrow[pb][mcnt[pb]] = pr; mcol[pb][mcnt[pb]] = pc;
                mwr[pb][mcnt[pb]]  = pw; mtag[pb][mcnt[pb]] = pt;
                mcnt[pb]++;
            end
        end
        @(negedge clk);
        push_valid = 0; query_valid = 0;
        check("R7 res_valid", int'(res_valid), int'(dq));
        if (dq) begin
            check({rq, " cmd"}, int'(res_cmd), ecmd);
            check("R9 bank", int'(res_bank), qb);
            if (ecmd != 0) begin
                check({rq, " row"}, int'(res_row), erow);
                check({rq, " col"}, int'(res_col), ecol);
                check({rq, " tag"}, int'(res_tag), etag);
            end
        end
    endtask

    task automatic push(int b, int r, int c, int w, int t);
        step(1, b, r, c, w, t, 0, 0, -1, "R3");
    endtask

    task automatic query(int b, int open, string rq);
        step(0, 0, 0, 0, 0, 0, 1, b, open, rq);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int b = 0; b < NB; b++) mcnt[b] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 res_valid", int'(res_valid), 0);
        check("R1 push_ready", int'(push_ready), 1);

        // R2: empty banks report NOP
        for (int b = 0; b < NB; b++) query(b, b - 1, "R2");

        // R3: fill each bank past capacity; the extra push must be refused
        for (int b = 0; b < NB; b++)
            for (int i = 0; i <= DEPTH; i++)
                push(b, (i * 3 + b) % 5, i, (i + b) % 2, (b * 8 + i) % 16);

        // Sweep open-row states per bank: closed (R5), hits (R4), unmatched row 6 (R6)
        for (int b = 0; b < NB; b++) begin
            query(b, -1, "R5");
            query(b, 6, "R6");
            for (int o = 0; o < 5; o++) query(b, o, "R4");
            query(b, -1, "R5");
            query(b, 6, "R6");
            // R9: other banks' queues untouched, drained below
        end
        for (int b = 0; b < NB; b++) begin
            while (mcnt[b] > 0) query(b, mrow[b][0], "R4");
            query(b, 3, "R2");
        end

        // R8: middle removal together with a push on the same bank
        push(2, 2, 1, 0, 1);
        push(2, 5, 2, 1, 2);
        push(2, 2, 3, 1, 3);
        step(1, 2, 7, 4, 0, 4, 1, 2, 5, "R8");
        step(1, 3, 9, 9, 1, 9, 1, 2, 2, "R8");
        query(2, -1, "R8");
        query(2, 2, "R8");
        query(2, 9, "R8");
        query(2, 7, "R8");
        query(2, 7, "R2");
        query(3, 9, "R9");
        query(3, 9, "R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule